// File: doc/BRIEF.md
# TDM Transmit Slot Mask Controller

This block sits between a register bus and the data pins of a multi-lane time-division-multiplexed serial transmitter. A frame holds up to 32 slots. A 32-bit slot-enable mask is reached through two 24-bit bus registers of 16 used bits each. For every slot the block decides whether the lane pins are driven or released, and it moves the data word of each lane into its shift register. It also raises the transmit-empty flag, the underrun flag and the interrupt request.

Mask writes land in a staging copy. The staging copy is copied into the active mask on the frame-sync pulse that opens slot 0, so a frame never sees a mask change in the middle. A disabled slot still loads the shift registers but leaves the flags untouched. A separate skip strobe releases the pins for the next slot, even when the mask enables that slot.

Bit and frame timing come from outside as a one-cycle bit tick and a frame-sync qualifier. Every slot change, output-enable change and shifted bit happens on a clock edge where the tick is high.

Top module: `tdm_slot_mask_tx`

## Requirements
- R1: After hardware reset (rst_n low) or after a one-cycle soft_rst pulse, all 32 mask bits are 1 in both the staging copy and the active copy. Both registers then read 0x00FFFF, tx_oe is 0, and tx_tde and tx_tue are 0.
- R2: reg_addr 0 selects slots 0..15 and reg_addr 1 selects slots 16..31. Register bit k maps to slot k, or to slot 16+k for the high register. reg_rdata returns the last written staging value in bits 15:0, and bits 23:16 always read 0.
- R3: A mask write becomes active only at the next frame_sync tick. The frame in progress keeps the mask it latched at its own start.
- R4: In an enabled slot, every lane with lane_en set drives tx_oe=1 for the whole slot. The lane's word goes out MSB first, one bit per tick, starting on the tick that opens the slot. tx_tde is set on that same tick.
- R5: In a disabled slot, tx_oe is 0 on all lanes. The data word is still loaded into the shift register, and neither tx_tde nor tx_tue is set.
- R6: A word written after tx_tde rises is sent in the next enabled slot, with disabled slots in between skipped. A disabled slot does not use up the word.
- R7: An enabled slot that opens with no data write since the previous enabled transfer, and with no skip pending, sets tx_tue and sends the previous word again.
- R8: A skip_we pulse makes the next slot start with tx_oe 0 on all lanes, whatever its mask bit, and it never sets tx_tue. If the mask enables that slot, tx_tde is still set. The skip is used up by that slot.
- R9: slots_per_frame (1..32) is the number of slots in a frame. On the tick after the last bit of the last slot, tx_oe drops to 0. The block then stays idle until the next frame_sync tick.
- R10: tx_oe and tx_dat change only on clock edges where bit_tick is 1. They take their new value in the cycle after that edge.
- R11: A data write clears tx_tde and tx_tue. A skip write clears tx_tde. tx_irq equals tx_tde AND irq_en. If a slot opens in the same cycle as a write, setting a flag wins over clearing it.
- R12: A lane with lane_en 0 keeps tx_oe 0 in every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset pulse |
| reg_we | input | 1 | Mask register write strobe |
| reg_addr | input | 1 | Mask register select (0 low half, 1 high half) |
| reg_wdata | input | 24 | Mask register write data |
| reg_rdata | output | 24 | Mask register read data for reg_addr |
| data_we | input | 1 | Data register write strobe, all lanes |
| data_wdata | input | LANES*SLOT_BITS | Words for all lanes, lane 0 in the low bits |
| skip_we | input | 1 | Skip-next-slot write strobe |
| bit_tick | input | 1 | One-cycle bit clock enable |
| frame_sync | input | 1 | Qualifies bit_tick as the first bit of slot 0 |
| slots_per_frame | input | 6 | Slots per frame, 1..32 |
| lane_en | input | LANES | Per-lane transmitter enable |
| irq_en | input | 1 | Interrupt enable |
| tx_dat | output | LANES | Serial data per lane |
| tx_oe | output | LANES | Pad output enable per lane |
| tx_tde | output | 1 | Transmit-empty flag |
| tx_tue | output | 1 | Transmit-underrun flag |
| tx_irq | output | 1 | Transmit-empty interrupt request |

## Verification
Slot decisions, shifted bits and flag updates all land at the clock edge that samples bit_tick, so they are due exactly one cycle after the tick is presented. The bench applies each tick at a falling edge and compares at the next falling edge. Register read data is combinational, so it is sampled in the same cycle as the address. Writes and skips take effect one edge after the strobe. Between ticks the bench also compares the outputs in idle cycles, which confirms they hold still when no tick arrives.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
   localparam int REG_W  = 24;
   localparam int HALF_W = 16;
   localparam int MASK_W = 2 * HALF_W;
   localparam int IDX_W  = $clog2(MASK_W);
   localparam logic ADDR_LO = 1'b0;
   localparam logic ADDR_HI = 1'b1;
endpackage

// File: rtl/tsm_mask_regs.sv
module tsm_mask_regs
   import tsm_pkg::*;
#(
   parameter int SLOT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              reg_we,
   input  logic              reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              frame_start,
   input  logic [SLOT_W-1:0] slot_idx,
   output logic              slot_en
);
   logic [MASK_W-1:0] stage_q;
   logic [MASK_W-1:0] active_q;
   logic [IDX_W-1:0]  idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q  <= '1;
         active_q <= '1;
      end else if (soft_rst) begin
         stage_q  <= '1;
         active_q <= '1;
      end else begin
         if (reg_we && reg_addr == ADDR_HI) stage_q[MASK_W-1:HALF_W] <= reg_wdata[HALF_W-1:0];
         if (reg_we && reg_addr == ADDR_LO) stage_q[HALF_W-1:0]      <= reg_wdata[HALF_W-1:0];
         if (frame_start)                   active_q                 <= stage_q;
      end
   end

   assign idx       = IDX_W'(slot_idx);
   // Slot 0 of a new frame already sees the staging copy being latched.
   assign slot_en   = frame_start ? stage_q[0] : active_q[idx];
   assign reg_rdata = {{(REG_W-HALF_W){1'b0}},
                       (reg_addr == ADDR_HI) ? stage_q[MASK_W-1:HALF_W] : stage_q[HALF_W-1:0]};
endmodule

// File: rtl/tsm_slot_timer.sv
module tsm_slot_timer #(
   parameter int SLOT_BITS = 4,
   parameter int MAX_SLOTS = 32,
   parameter int SLOT_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              bit_tick,
   input  logic              frame_sync,
   input  logic [SLOT_W-1:0] slots_cfg,
   output logic              frame_start,
   output logic              slot_start,
   output logic              frame_end,
   output logic              shift_tick,
   output logic [SLOT_W-1:0] slot_idx,
   output logic              running
);
   localparam int BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

   logic [BIT_W-1:0]  bit_q;
   logic [SLOT_W-1:0] slot_q, slot_nxt, cfg_eff;
   logic              run_q, last_bit, more;

   always_comb begin
      cfg_eff = slots_cfg;
      if (slots_cfg == '0)                        cfg_eff = SLOT_W'(1);
      else if (slots_cfg > SLOT_W'(MAX_SLOTS))    cfg_eff = SLOT_W'(MAX_SLOTS);
   end

   assign slot_nxt    = slot_q + SLOT_W'(1);
   assign last_bit    = (bit_q == BIT_W'(SLOT_BITS - 1));
   assign more        = (slot_nxt < cfg_eff);
   assign frame_start = bit_tick & frame_sync;
   assign slot_start  = frame_start | (bit_tick & run_q & last_bit & more);
   assign frame_end   = bit_tick & ~frame_sync & run_q & last_bit & ~more;
   assign shift_tick  = bit_tick & ~frame_sync & run_q & ~last_bit;
   assign slot_idx    = frame_start ? '0 : slot_nxt;
   assign running     = run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         bit_q  <= '0;
         slot_q <= '0;
      end else if (soft_rst) begin
         run_q  <= 1'b0;
         bit_q  <= '0;
         slot_q <= '0;
      end else if (frame_start) begin
         run_q  <= 1'b1;
         bit_q  <= '0;
         slot_q <= '0;
      end else if (slot_start) begin
         bit_q  <= '0;
         slot_q <= slot_nxt;
      end else if (frame_end) begin
         run_q  <= 1'b0;
      end else if (shift_tick) begin
         bit_q  <= bit_q + BIT_W'(1);
      end
   end
endmodule

// File: rtl/tsm_lane.sv
module tsm_lane #(
   parameter int SLOT_BITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst,
   input  logic                 data_we,
   input  logic [SLOT_BITS-1:0] data_in,
   input  logic                 load,
   input  logic                 shift,
   output logic                 ser_out
);
   logic [SLOT_BITS-1:0] hold_q, shf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         shf_q  <= '0;
      end else if (soft_rst) begin
         hold_q <= '0;
         shf_q  <= '0;
      end else begin
         if (data_we) hold_q <= data_in;
         if (load)       shf_q <= hold_q;
         else if (shift) shf_q <= shf_q << 1;
      end
   end

   assign ser_out = shf_q[SLOT_BITS-1];
endmodule

// File: rtl/tsm_flag_ctrl.sv
module tsm_flag_ctrl #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             slot_start,
   input  logic             frame_end,
   input  logic             slot_en,
   input  logic             data_we,
   input  logic             skip_we,
   input  logic [LANES-1:0] lane_en,
   input  logic             irq_en,
   output logic [LANES-1:0] oe,
   output logic             tde,
   output logic             tue,
   output logic             irq
);
   logic [LANES-1:0] oe_q;
   logic             tde_q, tue_q, fresh_q, skip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q <= '0; tde_q <= 1'b0; tue_q <= 1'b0; fresh_q <= 1'b0; skip_q <= 1'b0;
      end else if (soft_rst) begin
         oe_q <= '0; tde_q <= 1'b0; tue_q <= 1'b0; fresh_q <= 1'b0; skip_q <= 1'b0;
      end else begin
         // Bus writes first: a slot opening in the same cycle overrides the clears.
         if (data_we) begin
            fresh_q <= 1'b1;
            tde_q   <= 1'b0;
            tue_q   <= 1'b0;
         end
         if (skip_we) begin
            skip_q <= 1'b1;
            tde_q  <= 1'b0;
         end
         if (frame_end) oe_q <= '0;
         if (slot_start) begin
            skip_q <= skip_we;
            if (skip_q) begin
               oe_q <= '0;
               if (slot_en) tde_q <= 1'b1;
            end else if (slot_en) begin
               oe_q    <= lane_en;
               tde_q   <= 1'b1;
               fresh_q <= data_we;
               if (!fresh_q) tue_q <= 1'b1;
            end else begin
               oe_q <= '0;
            end
         end
      end
   end

   assign oe  = oe_q;
   assign tde = tde_q;
   assign tue = tue_q;
   assign irq = tde_q & irq_en;
endmodule

// File: rtl/tdm_slot_mask_tx.sv
module tdm_slot_mask_tx
   import tsm_pkg::*;
#(
   parameter int LANES     = 2,
   parameter int SLOT_BITS = 4,
   parameter int MAX_SLOTS = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       soft_rst,
   input  logic                       reg_we,
   input  logic                       reg_addr,
   input  logic [23:0]                reg_wdata,
   output logic [23:0]                reg_rdata,
   input  logic                       data_we,
   input  logic [LANES*SLOT_BITS-1:0] data_wdata,
   input  logic                       skip_we,
   input  logic                       bit_tick,
   input  logic                       frame_sync,
   input  logic [5:0]                 slots_per_frame,
   input  logic [LANES-1:0]           lane_en,
   input  logic                       irq_en,
   output logic [LANES-1:0]           tx_dat,
   output logic [LANES-1:0]           tx_oe,
   output logic                       tx_tde,
   output logic                       tx_tue,
   output logic                       tx_irq
);
   localparam int SLOT_W = 6;

   generate
      if (LANES < 1)                       $error("LANES must be at least 1");
      if (SLOT_BITS < 1)                   $error("SLOT_BITS must be at least 1");
      if (MAX_SLOTS < 1 || MAX_SLOTS > 32) $error("MAX_SLOTS must be 1..32");
   endgenerate

   logic              frame_start, slot_start, frame_end, shift_tick, slot_en, running;
   logic [SLOT_W-1:0] slot_idx;

   tsm_mask_regs #(.SLOT_W(SLOT_W)) u_regs (
      .clk, .rst_n, .soft_rst, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .frame_start, .slot_idx, .slot_en
   );

   tsm_slot_timer #(.SLOT_BITS(SLOT_BITS), .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_timer (
      .clk, .rst_n, .soft_rst, .bit_tick, .frame_sync, .slots_cfg(slots_per_frame),
      .frame_start, .slot_start, .frame_end, .shift_tick, .slot_idx, .running
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      tsm_lane #(.SLOT_BITS(SLOT_BITS)) u_lane (
         .clk, .rst_n, .soft_rst, .data_we,
         .data_in(data_wdata[g*SLOT_BITS +: SLOT_BITS]),
         .load(slot_start), .shift(shift_tick), .ser_out(tx_dat[g])
      );
   end

   tsm_flag_ctrl #(.LANES(LANES)) u_flags (
      .clk, .rst_n, .soft_rst, .slot_start, .frame_end, .slot_en,
      .data_we, .skip_we, .lane_en, .irq_en,
      .oe(tx_oe), .tde(tx_tde), .tue(tx_tue), .irq(tx_irq)
   );
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic             bit_tick,
   input logic [23:0]      reg_rdata,
   input logic [LANES-1:0] tx_oe,
   input logic             tx_tde,
   input logic             tx_tue,
   input logic             tx_irq,
   input logic             running
);
   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[23:16] == 8'h00);

   p_soft_reset_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> reg_rdata[15:0] == 16'hFFFF);

   p_oe_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_tick && !soft_rst) |=> $stable(tx_oe));

   p_underrun_with_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_tue) |-> tx_tde);

   p_irq_needs_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> tx_tde);

   p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> tx_oe == '0);
endmodule

bind tdm_slot_mask_tx tsm_checker #(.LANES(LANES)) u_tsm_checker (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bit_tick(bit_tick),
   .reg_rdata(reg_rdata), .tx_oe(tx_oe), .tx_tde(tx_tde), .tx_tue(tx_tue),
   .tx_irq(tx_irq), .running(running)
);

// File: tb/test_tdm_slot_mask_tx.sv
module test_tdm_slot_mask_tx;
   localparam int L  = 2;
   localparam int SB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_rst = 1'b0, reg_we = 1'b0, reg_addr = 1'b0;
   logic [23:0]   reg_wdata = '0;
   logic [23:0]   reg_rdata;
   logic          data_we = 1'b0;
   logic [L*SB-1:0] data_wdata = '0;
   logic          skip_we = 1'b0, bit_tick = 1'b0, frame_sync = 1'b0;
   logic [5:0]    slots_per_frame = 6'd8;
   logic [L-1:0]  lane_en = '1;
   logic          irq_en = 1'b1;
   logic [L-1:0]  tx_dat, tx_oe;
   logic          tx_tde, tx_tue, tx_irq;

   always #5 clk = ~clk;

   tdm_slot_mask_tx #(.LANES(L), .SLOT_BITS(SB), .MAX_SLOTS(32)) i_tdm_slot_mask_tx (.*);

   int checks = 0, failures = 0;
   bit done = 1'b0;

   // Bench-side expectation state
   logic [31:0]   m_wr = '1, m_act = '1;
   logic [SB-1:0] m_data [L];
   logic [SB-1:0] m_shift [L];
   logic [L-1:0]  m_oe = '0;
   bit            m_fresh = 0, m_skip = 0, m_tde = 0, m_tue = 0, m_run = 0;
   int            m_bit = 0, m_slot = 0, m_cfg = 8, wcount = 0;
   string         cur_tag = "";

   task automatic check(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic cmp_out(string tag);
      logic [L-1:0] ed;
      for (int i = 0; i < L; i++) ed[i] = m_shift[i][SB-1];
      check(tx_oe == m_oe, tag, "tx_oe", int'(tx_oe), int'(m_oe));
      check(tx_dat == ed, tag, "tx_dat", int'(tx_dat), int'(ed));
      check(tx_tde == m_tde, tag, "tx_tde", int'(tx_tde), int'(m_tde));
      check(tx_tue == m_tue, tag, "tx_tue", int'(tx_tue), int'(m_tue));
      check(tx_irq == (m_tde & irq_en), tag, "tx_irq", int'(tx_irq), int'(m_tde & irq_en));
   endtask

   task automatic model_reset();
      m_wr = '1; m_act = '1; m_oe = '0;
      m_fresh = 0; m_skip = 0; m_tde = 0; m_tue = 0; m_run = 0; m_bit = 0; m_slot = 0;
      for (int i = 0; i < L; i++) begin m_data[i] = '0; m_shift[i] = '0; end
   endtask

   task automatic idle_cycle(string tag);
      @(posedge clk); @(negedge clk);
      cmp_out(tag);
   endtask

   task automatic rd_check(logic a, logic [23:0] exp, string tag);
      reg_addr = a; #1;
      check(reg_rdata == exp, tag, "reg_rdata", int'(reg_rdata), int'(exp));
   endtask

   task automatic wr_reg(logic a, logic [23:0] v);
      reg_we = 1; reg_addr = a; reg_wdata = v;
      @(posedge clk); @(negedge clk);
      reg_we = 0;
      if (a) m_wr[31:16] = v[15:0]; else m_wr[15:0] = v[15:0];
   endtask

   task automatic wr_data();
      logic [L*SB-1:0] v;
      wcount++;
      v = (L*SB)'(wcount * 37 + 5);
      data_we = 1; data_wdata = v;
      @(posedge clk); @(negedge clk);
      data_we = 0;
      for (int i = 0; i < L; i++) m_data[i] = v[i*SB +: SB];
      m_fresh = 1; m_tde = 0; m_tue = 0;
   endtask

   task automatic wr_skip();
      skip_we = 1;
      @(posedge clk); @(negedge clk);
      skip_we = 0;
      m_skip = 1; m_tde = 0;
   endtask

   task automatic do_soft_reset();
      soft_rst = 1;
      @(posedge clk); @(negedge clk);
      soft_rst = 0;
      model_reset();
   endtask

   task automatic tick(bit fs);
      bit    start = 0, en = 0;
      string tag;
      tag = "R10";
      bit_tick = 1; frame_sync = fs;
      @(posedge clk);
      if (fs) begin
         m_act = m_wr; m_run = 1; m_bit = 0; m_slot = 0; start = 1;
      end else if (m_run) begin
         if (m_bit == SB-1) begin
            if (m_slot + 1 < m_cfg) begin m_slot++; m_bit = 0; start = 1; end
            else begin m_run = 0; m_oe = '0; tag = "R9"; end
         end else begin
            m_bit++;
            for (int i = 0; i < L; i++) m_shift[i] = m_shift[i] << 1;
            tag = "R4";
         end
      end else tag = "R9";
      if (start) begin
         en = m_act[m_slot];
         for (int i = 0; i < L; i++) m_shift[i] = m_data[i];
         if (m_skip) begin
            m_oe = '0; m_skip = 0; tag = "R8";
            if (en) m_tde = 1;
         end else if (en) begin
            m_oe = lane_en; m_tde = 1;
            if (!m_fresh) begin m_tue = 1; tag = "R7"; end else tag = "R4";
            m_fresh = 0;
         end else begin
            m_oe = '0; tag = "R5";
         end
      end
      @(negedge clk);
      bit_tick = 0; frame_sync = 0;
      cmp_out(cur_tag != "" ? cur_tag : tag);
   endtask

   // policy: 0 never service, 1 always refill, 2 alternate skip and refill
   task automatic run_frame(int cfg, int policy);
      int k = 0;
      m_cfg = cfg; slots_per_frame = 6'(cfg);
      tick(1);
      for (int t = 1; t < cfg*SB + 2; t++) begin
         if (m_tde && policy == 1) wr_data();
         if (m_tde && policy == 2) begin
            if (k % 2 == 1) wr_skip(); else wr_data();
            k++;
         end
         idle_cycle("R10");
         tick(0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rd_check(1'b0, 24'h00FFFF, "R1");
      rd_check(1'b1, 24'h00FFFF, "R1");
      cmp_out("R1");
      // R2 layout, reserved bits, readback of staging value
      wr_reg(1'b0, 24'hFF1234);
      wr_reg(1'b1, 24'hAB8765);
      rd_check(1'b0, 24'h001234, "R2");
      rd_check(1'b1, 24'h008765, "R2");
      // all slots enabled, first frame without data: underruns (R7)
      wr_reg(1'b0, 24'h00FFFF); wr_reg(1'b1, 24'h00FFFF);
      run_frame(4, 0);
      // R11 flag clearing and irq gating
      check(tx_tde == 1'b1, "R11", "tde before write", int'(tx_tde), 1);
      irq_en = 0; #1;
      check(tx_irq == 1'b0, "R11", "irq masked", int'(tx_irq), 0);
      irq_en = 1;
      wr_data();
      check(tx_tde == 1'b0 && tx_tue == 1'b0, "R11", "flags after data write",
            int'({tx_tde, tx_tue}), 0);
      // R4 refilled frame with a mixed mask
      wr_reg(1'b0, 24'h0000B5);
      run_frame(8, 1);
      // R6 sparse mask, data waits for next enabled slot
      cur_tag = "R6";
      wr_reg(1'b0, 24'h000049);
      run_frame(8, 1);
      cur_tag = "";
      // R8 skip writes alternating with data
      wr_reg(1'b0, 24'h0000FF);
      run_frame(8, 2);
      // R3 mid-frame mask write must not alter the current frame
      cur_tag = "R3";
      m_cfg = 8; slots_per_frame = 6'd8;
      tick(1);
      for (int t = 1; t < 8*SB + 2; t++) begin
         if (t == 5) wr_reg(1'b0, 24'h000000);
         if (m_tde) wr_data();
         tick(0);
      end
      rd_check(1'b0, 24'h000000, "R3");
      run_frame(8, 1);
      cur_tag = "";
      // R12 lane enable
      cur_tag = "R12";
      wr_reg(1'b0, 24'h00FFFF);
      lane_en = 2'b01;
      run_frame(6, 1);
      lane_en = 2'b11;
      cur_tag = "";
      // R9 boundaries: one-slot frame and a full 32-slot frame with high mask
      run_frame(1, 1);
      wr_reg(1'b0, 24'h00A00F); wr_reg(1'b1, 24'h00F0C3);
      run_frame(32, 1);
      // R1 soft reset in the middle of a frame
      m_cfg = 8; slots_per_frame = 6'd8;
      tick(1); tick(0); tick(0); tick(0); tick(0);
      do_soft_reset();
      cmp_out("R1");
      rd_check(1'b0, 24'h00FFFF, "R1");
      rd_check(1'b1, 24'h00FFFF, "R1");
      wr_data();
      run_frame(3, 1);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule